// File: doc/BRIEF.md
# Configurable I/O Logic Macrocell

This block is one pin cell of a programmable logic device. A set of architecture bits configures it. The output path can be combinatorial, or it can pass through a storage element. That storage element can be an edge-triggered register or a level-sensitive latch, and each configuration has a selectable output polarity. The cell takes a sum-of-products value from the logic array. It also takes per-cell preset, reset, clock and output-enable product terms, plus a clock pin and an output-enable pin shared by all cells. It drives a tri-state pad model and returns feedback to the array.

The storage element can sit on the output side, where it captures the array sum and drives the pad. It can also sit on the input side, where it captures the pad value and feeds it back to the array as an input register or latch. A parameter chooses between two feedback variants. The single-feedback variant returns either the pad or the stored value, as a bit selects. The dual-feedback variant always returns both. Test access is provided by a synchronous preload of the storage element and an observe output of the stored bit.

The cell runs in one system clock domain. The selected clock or enable source is sampled on each system clock edge. In register mode the cell captures on an inactive-to-active transition of that source. In latch mode the storage follows its data input while the source is active. Preset and reset take effect at the next system clock edge, whatever the state of the selected cell clock.

Top module: `io_macrocell`

## Requirements
- R1: Reset (`rst` high at a clock edge) clears the stored bit, so `obs_q` reads 0 after that edge. This holds both at start-up and when reset is applied during operation.
- R2: With `cfg_combo`=1 the pad value is the array input: `pad_out` = `sop_in` XOR `cfg_inv`, combinationally.
- R3: `cfg_inv`=1 inverts the driven value (active-low output). `cfg_inv`=0 drives the value unchanged.
- R4: With `cfg_reg`=1 the storage is a register. It captures its data exactly once, at the first system clock edge at which the selected enable is seen active after being inactive on the previous edge. It holds while the enable stays high or stays low.
- R5: With `cfg_reg`=0 the storage is a latch. It loads its data at every system clock edge where the selected enable is active, and holds while that enable is inactive.
- R6: `cfg_clk_sel` picks the enable source. 00 is the common pin `pin_clk`, active high. 01 is `pin_clk`, active low. 10 is the product term `pt_clk`, active high. 11 is `pt_clk`, active low.
- R7: With `cfg_out_dir`=1 the storage captures `sop_in`, and in stored mode (`cfg_combo`=0) `pad_out` = stored bit XOR `cfg_inv`. With `cfg_out_dir`=0 the storage captures the pad value, and `pad_out` = `sop_in` XOR `cfg_inv`.
- R8: `cfg_oe_mode` sets `pad_oe`. 00 follows `pin_oe`. 01 follows `pt_oe`. 10 is always 1. 11 is always 0.
- R9: `pt_reset` high forces the stored bit to 0 at the next clock edge. `pt_preset` high, with `pt_reset` low, forces it to 1. Reset wins when both are high, and neither depends on the selected enable.
- R10: `preload_en` high, with preset and reset low, loads `preload_val` into the stored bit at the next clock edge, whatever the enable state.
- R11: The pad value is `pad_out` when `pad_oe`=1 and `pin_in` otherwise. In the single-feedback variant (`DUAL_FB`=0), `fb_a` is the stored bit when `cfg_fb_store`=1 and the pad value when it is 0, and `fb_b` is 0. In the dual-feedback variant, `fb_a` is the pad value and `fb_b` is the stored bit.
- R12: `obs_q` shows the stored bit at all times, including while `pad_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_combo | input | 1 | 1 = combinatorial output, 0 = through storage |
| cfg_inv | input | 1 | 1 = active-low output |
| cfg_reg | input | 1 | 1 = register, 0 = latch |
| cfg_out_dir | input | 1 | 1 = storage on output side, 0 = on input side |
| cfg_clk_sel | input | 2 | Enable source and polarity |
| cfg_oe_mode | input | 2 | Output-enable mode |
| cfg_fb_store | input | 1 | Single-feedback source: 1 = stored bit, 0 = pad |
| sop_in | input | 1 | Sum-of-products from the array |
| pt_preset | input | 1 | Preset product term |
| pt_reset | input | 1 | Reset product term |
| pt_clk | input | 1 | Clock/enable product term |
| pin_clk | input | 1 | Common clock/enable pin |
| pin_oe | input | 1 | Common output-enable pin |
| pt_oe | input | 1 | Output-enable product term |
| pin_in | input | 1 | Value driven onto the pad from outside |
| preload_en | input | 1 | Preload strobe |
| preload_val | input | 1 | Preload data |
| pad_out | output | 1 | Value the cell drives on the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb_a | output | 1 | First feedback to the array |
| fb_b | output | 1 | Second feedback to the array (dual variant) |
| obs_q | output | 1 | Observed stored bit |

## Verification
The assertions assume that the configuration inputs and test strobes change only between clock edges. They also assume that reset is applied at least once before any check applies. The bench drives every input at the falling clock edge and raises reset for the first cycles. The hold property for latch mode also assumes that no preload, preset or reset is pending in the same cycle. The stimulus keeps those strobes low while it exercises holding. When it changes the enable source, the bench first sets the new source to its inactive level, so that no capture happens unplanned.

// File: rtl/io_mc_pkg.sv
package io_mc_pkg;

  typedef enum logic [1:0] {
    CS_PIN_HI = 2'b00,
    CS_PIN_LO = 2'b01,
    CS_PT_HI  = 2'b10,
    CS_PT_LO  = 2'b11
  } clk_src_e;

  typedef enum logic [1:0] {
    OE_PIN  = 2'b00,
    OE_PT   = 2'b01,
    OE_ON   = 2'b10,
    OE_OFF  = 2'b11
  } oe_mode_e;

endpackage

// File: rtl/io_mc_clksel.sv
module io_mc_clksel
  import io_mc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       is_reg,
  input  logic       pin_clk,
  input  logic       pt_clk,
  output logic       cap
);
  clk_src_e src;
  logic     en_now;
  logic     en_prev;

  assign src = clk_src_e'(sel);

  always_comb begin
    case (src)
      CS_PIN_HI: en_now = pin_clk;
      CS_PIN_LO: en_now = ~pin_clk;
      CS_PT_HI:  en_now = pt_clk;
      default:   en_now = ~pt_clk;
    endcase
  end

  // Previous enable starts high so a source already active at reset release
  // does not count as an edge.
  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b1;
    else     en_prev <= en_now;
  end

  assign cap = is_reg ? (en_now & ~en_prev) : en_now;
endmodule

// File: rtl/io_mc_store.sv
module io_mc_store (
  input  logic clk,
  input  logic rst,
  input  logic cap,
  input  logic d,
  input  logic force_set,
  input  logic force_clr,
  input  logic pl_en,
  input  logic pl_val,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)            q <= 1'b0;
    else if (force_clr) q <= 1'b0;
    else if (force_set) q <= 1'b1;
    else if (pl_en)     q <= pl_val;
    else if (cap)       q <= d;
  end
endmodule

// File: rtl/io_mc_oe.sv
module io_mc_oe
  import io_mc_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       pin_oe,
  input  logic       pt_oe,
  output logic       oe
);
  oe_mode_e m;
  assign m = oe_mode_e'(mode);

  always_comb begin
    case (m)
      OE_PIN:  oe = pin_oe;
      OE_PT:   oe = pt_oe;
      OE_ON:   oe = 1'b1;
      default: oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/io_macrocell.sv
module io_macrocell #(
  parameter bit DUAL_FB = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_combo,
  input  logic       cfg_inv,
  input  logic       cfg_reg,
  input  logic       cfg_out_dir,
  input  logic [1:0] cfg_clk_sel,
  input  logic [1:0] cfg_oe_mode,
  input  logic       cfg_fb_store,
  input  logic       sop_in,
  input  logic       pt_preset,
  input  logic       pt_reset,
  input  logic       pt_clk,
  input  logic       pin_clk,
  input  logic       pin_oe,
  input  logic       pt_oe,
  input  logic       pin_in,
  input  logic       preload_en,
  input  logic       preload_val,
  output logic       pad_out,
  output logic       pad_oe,
  output logic       fb_a,
  output logic       fb_b,
  output logic       obs_q
);
  logic cap;
  logic q;
  logic d;
  logic pad_val;
  logic out_data;

  io_mc_clksel u_clksel (
    .clk     (clk),
    .rst     (rst),
    .sel     (cfg_clk_sel),
    .is_reg  (cfg_reg),
    .pin_clk (pin_clk),
    .pt_clk  (pt_clk),
    .cap     (cap)
  );

  io_mc_oe u_oe (
    .mode   (cfg_oe_mode),
    .pin_oe (pin_oe),
    .pt_oe  (pt_oe),
    .oe     (pad_oe)
  );

  // Data source follows the storage direction.
  assign d = cfg_out_dir ? sop_in : pad_val;

  io_mc_store u_store (
    .clk       (clk),
    .rst       (rst),
    .cap       (cap),
    .d         (d),
    .force_set (pt_preset),
    .force_clr (pt_reset),
    .pl_en     (preload_en),
    .pl_val    (preload_val),
    .q         (q)
  );

  assign out_data = (!cfg_combo && cfg_out_dir) ? q : sop_in;
  assign pad_out  = out_data ^ cfg_inv;
  assign pad_val  = pad_oe ? pad_out : pin_in;
  assign obs_q    = q;

  generate
    if (DUAL_FB) begin : g_dual
      assign fb_a = pad_val;
      assign fb_b = q;
    end else begin : g_single
      assign fb_a = cfg_fb_store ? q : pad_val;
      assign fb_b = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/io_macrocell_checker.sv
module io_macrocell_checker (
  input logic       clk,
  input logic       rst,
  input logic       cfg_combo,
  input logic       cfg_inv,
  input logic       cfg_reg,
  input logic       cfg_out_dir,
  input logic [1:0] cfg_clk_sel,
  input logic [1:0] cfg_oe_mode,
  input logic       pt_preset,
  input logic       pt_reset,
  input logic       pt_clk,
  input logic       preload_en,
  input logic       preload_val,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       obs_q
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !obs_q);

  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (rst)
    pt_reset |=> !obs_q);

  assert_preset_sets_R9: assert property (@(posedge clk) disable iff (rst)
    (pt_preset && !pt_reset) |=> obs_q);

  assert_preload_loads_R10: assert property (@(posedge clk) disable iff (rst)
    (preload_en && !pt_preset && !pt_reset) |=> (obs_q == $past(preload_val)));

  assert_stored_drive_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_combo && cfg_out_dir) |-> (pad_out == (obs_q ^ cfg_inv)));

  assert_oe_off_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_oe_mode == 2'b11) |-> !pad_oe);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_reg && cfg_clk_sel == 2'b11 && pt_clk && !pt_preset && !pt_reset && !preload_en)
      |=> $stable(obs_q));
endmodule

bind io_macrocell io_macrocell_checker u_checker (
  .clk         (clk),
  .rst         (rst),
  .cfg_combo   (cfg_combo),
  .cfg_inv     (cfg_inv),
  .cfg_reg     (cfg_reg),
  .cfg_out_dir (cfg_out_dir),
  .cfg_clk_sel (cfg_clk_sel),
  .cfg_oe_mode (cfg_oe_mode),
  .pt_preset   (pt_preset),
  .pt_reset    (pt_reset),
  .pt_clk      (pt_clk),
  .preload_en  (preload_en),
  .preload_val (preload_val),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .obs_q       (obs_q)
);

// File: tb/io_macrocell_bench.sv
module io_macrocell_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_combo = 0, cfg_inv = 0, cfg_reg = 1, cfg_out_dir = 1, cfg_fb_store = 1;
  logic [1:0] cfg_clk_sel = 2'b00, cfg_oe_mode = 2'b10;
  logic sop_in = 0, pt_preset = 0, pt_reset = 0, pt_clk = 0, pin_clk = 0;
  logic pin_oe = 0, pt_oe = 0, pin_in = 0, preload_en = 0, preload_val = 0;
  logic pad_out, pad_oe, fb_a, fb_b, obs_q;
  logic d_pad_out, d_pad_oe, d_fb_a, d_fb_b, d_obs_q;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  io_macrocell #(.DUAL_FB(1'b0)) u_io_macrocell (
    .clk, .rst, .cfg_combo, .cfg_inv, .cfg_reg, .cfg_out_dir, .cfg_clk_sel,
    .cfg_oe_mode, .cfg_fb_store, .sop_in, .pt_preset, .pt_reset, .pt_clk,
    .pin_clk, .pin_oe, .pt_oe, .pin_in, .preload_en, .preload_val,
    .pad_out, .pad_oe, .fb_a, .fb_b, .obs_q);

  io_macrocell #(.DUAL_FB(1'b1)) u_io_macrocell_dual (
    .clk, .rst, .cfg_combo, .cfg_inv, .cfg_reg, .cfg_out_dir, .cfg_clk_sel,
    .cfg_oe_mode, .cfg_fb_store, .sop_in, .pt_preset, .pt_reset, .pt_clk,
    .pin_clk, .pin_oe, .pt_oe, .pin_in, .preload_en, .preload_val,
    .pad_out(d_pad_out), .pad_oe(d_pad_oe), .fb_a(d_fb_a), .fb_b(d_fb_b),
    .obs_q(d_obs_q));

  // {inv, oe_mode[1:0], pin_oe, pt_oe, sop, pin_in, exp_oe, exp_out, exp_fb}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    10'b0_10_0_0_1_0_1_1_1,
    10'b1_10_0_0_1_0_1_0_0,
    10'b0_00_1_0_0_1_1_0_0,
    10'b0_00_0_1_0_1_0_0_1,
    10'b1_01_0_1_0_0_1_1_1,
    10'b0_01_1_0_1_0_0_1_0,
    10'b0_11_1_1_1_0_0_1_0,
    10'b1_11_1_1_0_1_0_1_1
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic act, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    rst = 0;
    chk(obs_q == 0, "R1 reset q", obs_q, 0);
    chk(pad_out == 0, "R1 reset pad", pad_out, 0);

    // R2 R3 R8 R11 combinatorial table (single feedback from pad)
    cfg_combo = 1; cfg_fb_store = 0;
    for (int i = 0; i < NV; i++) begin
      {cfg_inv, cfg_oe_mode, pin_oe, pt_oe, sop_in, pin_in} = VEC[i][9:3];
      #1;
      chk(pad_oe == VEC[i][2], "R8 oe", pad_oe, VEC[i][2]);
      chk(pad_out == VEC[i][1], "R2 R3 out", pad_out, VEC[i][1]);
      chk(fb_a == VEC[i][0], "R11 pad fb", fb_a, VEC[i][0]);
      chk(d_fb_a == VEC[i][0], "R11 dual pad fb", d_fb_a, VEC[i][0]);
    end
    @(negedge clk);
    cfg_combo = 0; cfg_inv = 0; cfg_oe_mode = 2'b10; cfg_fb_store = 1;
    pin_in = 0; pin_oe = 0; pt_oe = 0;

    // R4 register on pin, active high
    sop_in = 1; pin_clk = 0; tick();
    chk(obs_q == 0, "R4 no edge", obs_q, 0);
    pin_clk = 1; tick();
    chk(obs_q == 1, "R4 capture", obs_q, 1);
    chk(pad_out == 1, "R7 stored drive", pad_out, 1);
    chk(fb_a == 1, "R11 stored fb", fb_a, 1);
    sop_in = 0; tick(); tick();
    chk(obs_q == 1, "R4 hold high", obs_q, 1);
    pin_clk = 0; tick();
    chk(obs_q == 1, "R4 hold falling", obs_q, 1);
    pin_clk = 1; tick();
    chk(obs_q == 0, "R4 second capture", obs_q, 0);
    cfg_inv = 1; #1;
    chk(pad_out == 1, "R3 inverted stored", pad_out, 1);
    @(negedge clk); cfg_inv = 0;

    // R6 pin active low
    cfg_clk_sel = 2'b01; sop_in = 1; tick();
    chk(obs_q == 0, "R6 pin low idle", obs_q, 0);
    pin_clk = 0; tick();
    chk(obs_q == 1, "R6 pin low capture", obs_q, 1);
    // R6 product term active high
    cfg_clk_sel = 2'b10; pt_clk = 0; sop_in = 0; tick();
    chk(obs_q == 1, "R6 pt idle", obs_q, 1);
    pt_clk = 1; tick();
    chk(obs_q == 0, "R6 pt capture", obs_q, 0);

    // R5 latch, product term active low
    cfg_reg = 0; cfg_clk_sel = 2'b11; sop_in = 1; tick();
    chk(obs_q == 0, "R5 latch hold", obs_q, 0);
    pt_clk = 0; tick();
    chk(obs_q == 1, "R5 transparent", obs_q, 1);
    sop_in = 0; tick();
    chk(obs_q == 0, "R5 follow low", obs_q, 0);
    sop_in = 1; tick();
    chk(obs_q == 1, "R5 follow high", obs_q, 1);
    pt_clk = 1; sop_in = 0; tick();
    chk(obs_q == 1, "R5 closed", obs_q, 1);

    // R9 preset/reset
    cfg_reg = 1; cfg_clk_sel = 2'b00; pin_clk = 0;
    pt_reset = 1; tick(); pt_reset = 0;
    chk(obs_q == 0, "R9 reset term", obs_q, 0);
    pt_preset = 1; tick();
    chk(obs_q == 1, "R9 preset term", obs_q, 1);
    pt_reset = 1; tick();
    chk(obs_q == 0, "R9 reset wins", obs_q, 0);
    pt_reset = 0; pt_preset = 0;

    // R10 preload, R12 observe with driver off
    cfg_oe_mode = 2'b11;
    preload_en = 1; preload_val = 1; tick();
    chk(obs_q == 1, "R10 preload one", obs_q, 1);
    chk(pad_oe == 0, "R12 oe off", pad_oe, 0);
    chk(obs_q == 1, "R12 observe", obs_q, 1);
    preload_val = 0; tick();
    chk(obs_q == 0, "R10 preload zero", obs_q, 0);
    preload_en = 0;

    // R7 input-side storage
    cfg_out_dir = 0; pin_in = 1; sop_in = 0; tick();
    pin_clk = 1; tick();
    chk(obs_q == 1, "R7 pin captured", obs_q, 1);
    chk(pad_out == 0, "R7 input side out", pad_out, 0);
    chk(fb_a == 1, "R11 single stored fb", fb_a, 1);
    cfg_fb_store = 0; pin_in = 0; #1;
    chk(fb_a == 0, "R11 single pad fb", fb_a, 0);
    chk(d_fb_a == 0, "R11 dual pad fb", d_fb_a, 0);
    chk(d_fb_b == 1, "R11 dual stored fb", d_fb_b, 1);
    chk(fb_b == 0, "R11 single fb_b", fb_b, 0);

    // R1 reset during operation
    @(negedge clk);
    rst = 1; tick(); rst = 0;
    chk(obs_q == 0, "R1 mid reset", obs_q, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule